// File: doc/BRIEF.md
# Serial Lane Packet Parser

This block sits on one bit-serial input lane of a multi-port router. It watches a single data bit together with two active-low strobes, a frame strobe and a valid strobe. From them it recovers one packet at a time.

Every packet has three parts in a fixed order:
- A 4-bit destination port, sent least significant bit first.
- A fixed stretch of five padding cycles.
- One or more payload bytes, each sent least significant bit first.

The sender raises the frame strobe on the last bit of the final byte. The parser hands each finished byte to the next stage on a parallel output. The output carries the byte, its destination tag, an end-of-packet marker, and a valid/ready handshake.

A broken packet raises a one-cycle error pulse and sends the parser back to idle. Two things break a packet: the valid strobe dropping while padding is expected, or the frame strobe ending the packet between byte boundaries.

The output holds a single byte. While the next stage refuses it, the byte stays on the pins and a stall indication is raised.

Top module: `pkt_lane_parser`

## Requirements
- R1: While reset is low, outValid, protoErr and stall are 0 and any partly received address or byte is dropped. After release the parser waits in idle for a new packet.
- R2: In idle, the first rising edge that samples frameN low starts a packet, and that edge takes address bit 0 from serIn. Address bits 1 to 3 follow on the next three edges. validN is not examined during these four edges.
- R3: The five edges after the address are padding. Each must see frameN low and validN high. The value of serIn during padding has no effect on any output.
- R4: After padding, each group of eight edges builds one byte, with the first bit in bit 0. outValid goes to 1 one cycle after the edge that samples bit 7. At that time outByte holds the byte and outDest holds the destination of its packet.
- R5: outLast is 1 with a byte exactly when frameN was sampled high together with its bit 7. That edge ends the packet, and the next frameN low sample in idle starts a new one.
- R6: A byte is taken by the next stage on an edge where outValid and outReady are both 1. After that edge outValid is 0 unless another byte completed on the same edge.
- R7: stall is 1 exactly when outValid is 1 and outReady is 0. While stalled, outByte, outDest and outLast stay unchanged. A byte that completes during a stall is discarded.
- R8: validN sampled low on any padding edge makes protoErr 1 for exactly the next cycle. The packet is then abandoned and no byte is emitted from it.
- R9: frameN sampled high on an address edge, a padding edge, or a data edge carrying bits 0 to 6 makes protoErr 1 for the next cycle. The parser returns to idle and drops the partial byte.
- R10: A byte that completes on the same edge as the held byte is accepted is loaded at once, so outValid stays 1 with the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data bit of the lane |
| frameN | input | 1 | Packet frame strobe, active low |
| validN | input | 1 | Payload valid strobe, active low |
| outReady | input | 1 | Next stage accepts the presented byte |
| outValid | output | 1 | A byte is presented |
| outByte | output | 8 | Presented payload byte |
| outDest | output | 4 | Destination port of the presented byte |
| outLast | output | 1 | Presented byte ends its packet |
| stall | output | 1 | Byte presented but refused |
| protoErr | output | 1 | One-cycle pulse after a framing violation |

## Verification
Two events can land on the same rising edge. One is a new byte completing on the serial side. The other is the handshake deciding whether the byte already held leaves. Whichever way that edge resolves, the byte is kept, replaced or discarded.

To provoke this, the bench drives outReady with a nine-cycle pattern against bytes that arrive every eight cycles. The phase between the two drifts by one cycle per byte. Over a packet of several bytes the completion therefore lands both on a release edge and on a refusal edge. A separate long refusal covers a byte arriving while the output is held.

A behavioural reference, counting bit positions from the packet start, predicts on every cycle which byte is presented. The bench compares that prediction against the output pins.

// File: rtl/lane_pkg.sv
package lane_pkg;

  // Strobes from the sequencer to the datapath, valid for the current edge.
  typedef struct packed {
    logic addrShift;  // take serIn into the destination register
    logic dataShift;  // take serIn into the byte register
    logic byteDone;   // this edge carries the top bit of a byte
    logic lastByte;   // that byte closes the packet
    logic errPulse;   // framing violation seen on this edge
  } lane_ctl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_PAD  = 2'd2,
    PH_DATA = 2'd3
  } lane_phase_t;

endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int ADDR_BITS  = 4,
  parameter int PAD_CYCLES = 5,
  parameter int BYTE_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      validN,
  output lane_ctl_t ctl
);

  localparam int MAX_A   = (ADDR_BITS > PAD_CYCLES) ? ADDR_BITS : PAD_CYCLES;
  localparam int CNT_MAX = (MAX_A > BYTE_BITS) ? MAX_A : BYTE_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] PAD_END  = CNT_W'(PAD_CYCLES - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_BITS - 1);

  lane_phase_t      phaseQ, phaseD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ;
    ctl    = '0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (!frameN) begin
          // start edge already carries address bit 0
          ctl.addrShift = 1'b1;
          phaseD        = PH_ADDR;
          cntD          = CNT_W'(1);
        end
      end
      PH_ADDR: begin
        if (frameN) begin
          ctl.errPulse = 1'b1;
          phaseD       = PH_IDLE;
          cntD         = '0;
        end else begin
          ctl.addrShift = 1'b1;
          if (cntQ == ADDR_END) begin
            phaseD = PH_PAD;
            cntD   = '0;
          end else begin
            cntD = cntQ + CNT_W'(1);
          end
        end
      end
      PH_PAD: begin
        if (frameN || !validN) begin
          ctl.errPulse = 1'b1;
          phaseD       = PH_IDLE;
          cntD         = '0;
        end else if (cntQ == PAD_END) begin
          phaseD = PH_DATA;
          cntD   = '0;
        end else begin
          cntD = cntQ + CNT_W'(1);
        end
      end
      PH_DATA: begin
        if (cntQ == BYTE_END) begin
          ctl.dataShift = 1'b1;
          ctl.byteDone  = 1'b1;
          ctl.lastByte  = frameN;
          cntD          = '0;
          if (frameN) phaseD = PH_IDLE;
        end else if (frameN) begin
          // frame closed in the middle of a byte
          ctl.errPulse = 1'b1;
          phaseD       = PH_IDLE;
          cntD         = '0;
        end else begin
          ctl.dataShift = 1'b1;
          cntD          = cntQ + CNT_W'(1);
        end
      end
      default: begin
        phaseD = PH_IDLE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
    end
  end

endmodule

// File: rtl/lane_dp.sv
module lane_dp
  import lane_pkg::*;
#(
  parameter int ADDR_BITS = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 outReady,
  input  lane_ctl_t            ctl,
  output logic                 outValid,
  output logic [BYTE_BITS-1:0] outByte,
  output logic [ADDR_BITS-1:0] outDest,
  output logic                 outLast,
  output logic                 stall,
  output logic                 protoErr
);

  logic [ADDR_BITS-1:0] addrQ;
  logic [BYTE_BITS-1:0] shiftQ;
  logic [BYTE_BITS-1:0] fullByte;
  logic                 canLoad;

  // Bits arrive low first: shift right, new bit enters at the top.
  assign fullByte = {serIn, shiftQ[BYTE_BITS-1:1]};
  assign stall    = outValid && !outReady;
  assign canLoad  = !stall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (ctl.addrShift) begin
      addrQ <= {serIn, addrQ[ADDR_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (ctl.errPulse) begin
      shiftQ <= '0;
    end else if (ctl.dataShift) begin
      shiftQ <= fullByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
      outDest  <= '0;
      outLast  <= 1'b0;
    end else if (canLoad) begin
      outValid <= ctl.byteDone;
      if (ctl.byteDone) begin
        outByte <= fullByte;
        outDest <= addrQ;
        outLast <= ctl.lastByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protoErr <= 1'b0;
    else       protoErr <= ctl.errPulse;
  end

endmodule

// File: rtl/pkt_lane_parser.sv
module pkt_lane_parser
  import lane_pkg::*;
#(
  parameter int ADDR_BITS  = 4,
  parameter int PAD_CYCLES = 5,
  parameter int BYTE_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 frameN,
  input  logic                 validN,
  input  logic                 outReady,
  output logic                 outValid,
  output logic [BYTE_BITS-1:0] outByte,
  output logic [ADDR_BITS-1:0] outDest,
  output logic                 outLast,
  output logic                 stall,
  output logic                 protoErr
);

  lane_ctl_t ctl;

  lane_ctrl #(
    .ADDR_BITS (ADDR_BITS),
    .PAD_CYCLES(PAD_CYCLES),
    .BYTE_BITS (BYTE_BITS)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .frameN(frameN),
    .validN(validN),
    .ctl   (ctl)
  );

  lane_dp #(
    .ADDR_BITS(ADDR_BITS),
    .BYTE_BITS(BYTE_BITS)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .outReady(outReady),
    .ctl     (ctl),
    .outValid(outValid),
    .outByte (outByte),
    .outDest (outDest),
    .outLast (outLast),
    .stall   (stall),
    .protoErr(protoErr)
  );

endmodule

// File: rtl/lane_parser_chk.sv
module lane_parser_chk #(
  parameter int ADDR_BITS = 4,
  parameter int BYTE_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 outReady,
  input logic                 outValid,
  input logic [BYTE_BITS-1:0] outByte,
  input logic [ADDR_BITS-1:0] outDest,
  input logic                 outLast,
  input logic                 protoErr
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte) && $stable(outDest) && $stable(outLast)));

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);

  // R9
  err_no_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !$rose(outValid));

endmodule

bind pkt_lane_parser lane_parser_chk #(
  .ADDR_BITS(ADDR_BITS),
  .BYTE_BITS(BYTE_BITS)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .outReady(outReady),
  .outValid(outValid),
  .outByte (outByte),
  .outDest (outDest),
  .outLast (outLast),
  .protoErr(protoErr)
);

// File: tb/test_pkt_lane_parser.sv
`timescale 1ns/1ps
module test_pkt_lane_parser;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic frameN = 1'b1;
  logic validN = 1'b1;
  logic outReady = 1'b1;
  logic outValid, outLast, stall, protoErr;
  logic [7:0] outByte;
  logic [3:0] outDest;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [7:0] payload [0:31];

  always #10 clk = ~clk;  // 50 MHz

  pkt_lane_parser i_pkt_lane_parser (
    .clk(clk), .rstN(rstN), .serIn(serIn), .frameN(frameN), .validN(validN),
    .outReady(outReady), .outValid(outValid), .outByte(outByte), .outDest(outDest),
    .outLast(outLast), .stall(stall), .protoErr(protoErr)
  );

  // ---------------- reference model: bit position since packet start ----
  bit         mInPkt = 0;
  int         mPos = 0;
  logic [3:0] mAddr = '0;
  logic [7:0] mCur = '0;
  logic       eValid = 0, eLast = 0, eErr = 0;
  logic [7:0] eByte = '0;
  logic [3:0] eDest = '0;

  always @(posedge clk) begin
    bit done, lastF, nErr;
    int bi;
    if (!rstN) begin
      mInPkt = 0; mPos = 0; mAddr = '0; mCur = '0;
      eValid = 0; eByte = '0; eDest = '0; eLast = 0; eErr = 0;
    end else begin
      done = 0; lastF = 0; nErr = 0;
      if (!mInPkt) begin
        if (!frameN) begin mInPkt = 1; mAddr[0] = serIn; mPos = 1; end
      end else if (mPos < 4) begin
        if (frameN) nErr = 1;
        else begin mAddr[mPos] = serIn; mPos++; end
      end else if (mPos < 9) begin
        if (frameN || !validN) nErr = 1;
        else mPos++;
      end else begin
        bi = (mPos - 9) % 8;
        if (bi == 7) begin
          mCur[bi] = serIn; done = 1; lastF = frameN;
          if (frameN) mInPkt = 0;
          mPos++;
        end else if (frameN) nErr = 1;
        else begin mCur[bi] = serIn; mPos++; end
      end
      if (nErr) begin mInPkt = 0; mPos = 0; end
      if (eValid && !outReady) begin
        // held
      end else if (done) begin
        eValid = 1; eByte = mCur; eDest = mAddr; eLast = lastF;
      end else begin
        eValid = 0;
      end
      eErr = nErr;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the driving instant
  always @(negedge clk) begin
    if (!finished) begin
      check(outValid === eValid, {curReq, "/R6"}, "outValid", outValid, eValid);
      check(stall === (eValid && !outReady), {curReq, "/R7"}, "stall", stall, eValid && !outReady);
      check(protoErr === eErr, {curReq, "/R8 R9"}, "protoErr", protoErr, eErr);
      if (eValid) begin
        check(outByte === eByte, {curReq, "/R4"}, "outByte", outByte, eByte);
        check(outDest === eDest, {curReq, "/R2"}, "outDest", outDest, eDest);
        check(outLast === eLast, {curReq, "/R5"}, "outLast", outLast, eLast);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input logic f, input logic v, input logic d);
    @(negedge clk); #1;
    frameN = f; validN = v; serIn = d;
  endtask

  task automatic fill(input int seed);
    for (int b = 0; b < 32; b++) payload[b] = 8'(seed * 37 + b * 13 + 5);
  endtask

  task automatic sendPkt(input logic [3:0] dst, input int nBytes, input logic padBit,
                         input int padErrAt, input int frameErrAt);
    for (int i = 0; i < 4; i++) tick(1'b0, i[0], dst[i]);
    for (int i = 0; i < 5; i++) begin
      if (i == padErrAt) begin tick(1'b0, 1'b0, 1'b1); tick(1'b1, 1'b1, 1'b0); return; end
      tick(1'b0, 1'b1, padBit);
    end
    for (int b = 0; b < nBytes; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (b * 8 + k == frameErrAt) begin
          tick(1'b1, 1'b0, payload[b][k]); tick(1'b1, 1'b1, 1'b0); return;
        end
        tick((b == nBytes - 1) && (k == 7), 1'b0, payload[b][k]);
      end
    end
    tick(1'b1, 1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 1'b0);
  endtask

  task automatic setReady(input logic r);
    @(negedge clk); #1; outReady = r;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected done");
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    check(outValid === 1'b0, "R1", "reset outValid", outValid, 0);
    check(protoErr === 1'b0, "R1", "reset protoErr", protoErr, 0);
    check(stall === 1'b0, "R1", "reset stall", stall, 0);
    #1 rstN = 1'b1;
    idle(3);

    curReq = "R2"; fill(1);
    sendPkt(4'd5, 1, 1'b1, -1, -1); idle(3);
    sendPkt(4'd10, 2, 1'b1, -1, -1); idle(2);

    curReq = "R5"; fill(2);
    sendPkt(4'd3, 3, 1'b1, -1, -1);
    sendPkt(4'd12, 2, 1'b1, -1, -1); idle(3);

    curReq = "R4"; fill(3);
    sendPkt(4'd15, 32, 1'b1, -1, -1); idle(3);

    curReq = "R3"; fill(4);  // pad line value does not matter
    sendPkt(4'd9, 2, 1'b0, -1, -1); idle(3);

    curReq = "R8"; fill(5);
    sendPkt(4'd6, 3, 1'b1, 2, -1); idle(2);
    sendPkt(4'd6, 2, 1'b1, 0, -1); idle(2);
    sendPkt(4'd7, 1, 1'b1, -1, -1); idle(2);

    curReq = "R9"; fill(6);
    sendPkt(4'd11, 3, 1'b1, -1, 13); idle(2);
    sendPkt(4'd11, 2, 1'b1, -1, 0); idle(2);
    tick(1'b0, 1'b1, 1'b1); tick(1'b0, 1'b1, 1'b0); tick(1'b1, 1'b1, 1'b0);  // frame lost in address
    idle(2);
    sendPkt(4'd2, 2, 1'b1, -1, -1); idle(3);

    curReq = "R7"; fill(7);
    fork
      sendPkt(4'd4, 4, 1'b1, -1, -1);
      begin
        repeat (20) @(negedge clk);
        #1 outReady = 1'b0;
        repeat (22) @(negedge clk);
        #1 outReady = 1'b1;
      end
    join
    idle(4);

    curReq = "R10"; fill(8);
    fork
      sendPkt(4'd13, 10, 1'b1, -1, -1);
      begin
        for (int p = 0; p < 10; p++) begin
          repeat (8) setReady(1'b0);
          setReady(1'b1);
        end
      end
    join
    setReady(1'b1);
    idle(6);

    curReq = "R1"; fill(9);
    fork
      sendPkt(4'd8, 4, 1'b1, -1, -1);
      begin
        repeat (22) @(negedge clk);
        #1 rstN = 1'b0;
        @(negedge clk);
        check(outValid === 1'b0, "R1", "mid-packet reset outValid", outValid, 0);
        check(stall === 1'b0, "R1", "mid-packet reset stall", stall, 0);
        #1 rstN = 1'b1;
      end
    join
    idle(45);
    fill(10);
    sendPkt(4'd1, 2, 1'b1, -1, -1); idle(4);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule